// File: doc/BRIEF.md
# Linked Descriptor Transfer Sequencer

This block walks a singly linked list of transfer descriptors held in memory and launches one serial transfer for each entry. Software writes the address of the first descriptor into the launch register. The sequencer then reads the descriptor's three words through a simple read port that allows one outstanding request. It unpacks the control word and presents the buffer address, byte count, direction, lane mode and keep-select flag to a transfer engine with a one-cycle start strobe. After the engine reports completion, the sequencer follows the link word. A zero link ends the walk.

When the chain ends, a completion status bit is set. A descriptor whose buffer address does not sit on a 32-byte boundary is not issued. Instead the walk stops and an error status bit is set. Status bits are cleared by writing ones to them. The interrupt line is high whenever a status bit and its enable bit are both set. The address of the descriptor in progress and its buffer address can be read back at any time. Moving the buffer data is the engine's job and is not part of this block.

Descriptor layout in memory:
- Word 0, at the descriptor address: the buffer address.
- Word 1, at +4: the link to the next descriptor.
- Word 2, at +8: the control word.

Register index map on `reg_addr`:
- 0: launch (write only).
- 1: interrupt enable.
- 2: status.
- 3: current descriptor address.
- 4: current buffer address.

Top module: `desc_chain_fetch`

## Requirements
- R1: A write to register index 0 while the block is idle starts a walk at the written address. The three descriptor words are read at that address, then +4, then +8.
- R2: The control word is decoded as follows:
  - bit 0 is the direction;
  - bits 3:1 are the lane mode;
  - bit 8 is the keep-select (fragment) flag;
  - bits 31:16 are the byte count.
  
  These fields and word 0 as the buffer address are presented on the engine outputs. They are qualified by a `xfer_start` pulse exactly one cycle wide.
- R3: The next descriptor is fetched only after `xfer_done`. The link word is followed, and a link of zero ends the walk after the current transfer.
- R4: When a walk ends normally, status bit 31 is set.
- R5: A descriptor whose buffer address has any of its low 5 bits set is not issued. The walk stops and status bit 1 is set instead of bit 31.
- R6: Writing a 1 to a status bit at register index 2 clears it, and writing 0 leaves it unchanged. `irq` is the OR over bits 31 and 1 of status AND enable, where enable is register index 1.
- R7: Register index 3 reads the address of the descriptor being processed or last processed. Register index 4 reads its buffer address.
- R8: A write to the launch register while a walk is in progress is ignored. The walk continues unchanged and no new walk starts.
- R9: At most one memory read is outstanding. `mem_req` is a single-cycle request, and no new request is made until `mem_rvalid` returns the previous word.
- R10: After reset the block is idle. `mem_req`, `xfer_start` and `irq` are low, and status, enable and both address readbacks are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Single-cycle memory read request |
| mem_addr | output | 32 | Byte address of the word requested |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_start | output | 1 | One-cycle transfer launch strobe |
| xfer_addr | output | 32 | Buffer address of the transfer |
| xfer_len | output | 16 | Byte count of the transfer |
| xfer_dir | output | 1 | Direction bit |
| xfer_mode | output | 3 | Lane mode |
| xfer_frag | output | 1 | Keep chip select asserted after this transfer |
| xfer_done | input | 1 | Transfer completion pulse from the engine |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following rules on every cycle:
- the memory request is a single-cycle strobe, and so is the start strobe;
- no transfer is ever issued with a buffer address off the 32-byte boundary;
- `irq` stays low while both enable bits are clear.

Some behaviour can only be shown by the bench's scenarios:
- the fetch addresses and the decoded fields for chains of one to four descriptors;
- that a walk ends on a zero link;
- that a misaligned entry stops the walk mid-chain with the error bit;
- that write-one-to-clear leaves bits written with zero untouched;
- that a launch during a walk is ignored.

// File: rtl/desc_chain_fetch.sv
module desc_chain_fetch #(
  parameter int ALIGN_BITS = 5,
  parameter int LEN_W      = 16,
  parameter int MODE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_start,
  output logic [31:0]       xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_dir,
  output logic [MODE_W-1:0] xfer_mode,
  output logic              xfer_frag,
  input  logic              xfer_done,
  output logic              irq
);

  localparam int DONE_BIT = 31;
  localparam int ERR_BIT  = 1;
  localparam int LEN_LO   = 32 - LEN_W;
  localparam int FRAG_BIT = 8;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT} state_t;

  state_t      st;
  logic [1:0]  widx;
  logic        pend;
  logic [31:0] cur_desc, buf_addr, link, ctrl_w;
  logic [1:0]  int_en;
  logic        st_done, st_err;

  wire start_wr  = reg_wr && reg_addr == 3'd0;
  wire en_wr     = reg_wr && reg_addr == 3'd1;
  wire clr_wr    = reg_wr && reg_addr == 3'd2;
  wire misalign  = |buf_addr[ALIGN_BITS-1:0];
  wire set_err   = st == S_ISSUE && misalign;
  wire set_done  = st == S_WAIT && xfer_done && link == 32'd0;

  logic unused_ctl;
  assign unused_ctl = ^{ctrl_w[LEN_LO-1:FRAG_BIT+1], ctrl_w[FRAG_BIT-1:MODE_W+1]};

  assign mem_req    = st == S_FETCH && !pend;
  assign mem_addr   = cur_desc + {28'd0, widx, 2'b00};
  assign xfer_start = st == S_ISSUE && !misalign;
  assign xfer_addr  = buf_addr;
  assign xfer_len   = ctrl_w[31:LEN_LO];
  assign xfer_dir   = ctrl_w[0];
  assign xfer_mode  = ctrl_w[MODE_W:1];
  assign xfer_frag  = ctrl_w[FRAG_BIT];
  assign irq        = (st_done && int_en[1]) || (st_err && int_en[0]);

  always_comb begin
    case (reg_addr)
      3'd1:    reg_rdata = {int_en[1], 29'd0, int_en[0], 1'b0};
      3'd2:    reg_rdata = {st_done, 29'd0, st_err, 1'b0};
      3'd3:    reg_rdata = cur_desc;
      3'd4:    reg_rdata = buf_addr;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en  <= 2'b00;
      st_done <= 1'b0;
      st_err  <= 1'b0;
    end else begin
      if (en_wr) int_en <= {reg_wdata[DONE_BIT], reg_wdata[ERR_BIT]};
      st_done <= set_done || (st_done && !(clr_wr && reg_wdata[DONE_BIT]));
      st_err  <= set_err  || (st_err  && !(clr_wr && reg_wdata[ERR_BIT]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      widx     <= 2'd0;
      pend     <= 1'b0;
      cur_desc <= 32'd0;
      buf_addr <= 32'd0;
      link     <= 32'd0;
      ctrl_w   <= 32'd0;
    end else begin
      case (st)
        S_IDLE: if (start_wr) begin
          cur_desc <= reg_wdata;
          widx     <= 2'd0;
          pend     <= 1'b0;
          st       <= S_FETCH;
        end
        S_FETCH: begin
          if (!pend) pend <= 1'b1;
          else if (mem_rvalid) begin
            pend <= 1'b0;
            case (widx)
              2'd0:    buf_addr <= mem_rdata;
              2'd1:    link     <= mem_rdata;
              default: ctrl_w   <= mem_rdata;
            endcase
            if (widx == 2'd2) begin
              widx <= 2'd0;
              st   <= S_ISSUE;
            end else begin
              widx <= 2'(widx + 2'd1);
            end
          end
        end
        S_ISSUE: st <= misalign ? S_IDLE : S_WAIT;
        S_WAIT: if (xfer_done) begin
          if (link == 32'd0) st <= S_IDLE;
          else begin
            cur_desc <= link;
            st       <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_chain_fetch_chk.sv
module desc_chain_fetch_chk #(
  parameter int ALIGN_BITS = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        xfer_start,
  input logic [31:0] xfer_addr,
  input logic        irq,
  input logic [1:0]  int_en
);

  a_r9_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  a_r5_aligned_issue: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> xfer_addr[ALIGN_BITS-1:0] == '0);

  a_r6_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    int_en == 2'b00 |-> !irq);

endmodule

bind desc_chain_fetch desc_chain_fetch_chk #(.ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .xfer_start(xfer_start),
  .xfer_addr(xfer_addr), .irq(irq), .int_en(int_en)
);

// File: tb/desc_chain_fetch_bench.sv
`timescale 1ns/1ps
module desc_chain_fetch_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = 32'd0;
  logic        xfer_start, xfer_dir, xfer_frag, xfer_done = 1'b0;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_len;
  logic [2:0]  xfer_mode;
  logic        irq;

  desc_chain_fetch u_desc_chain_fetch (.*);

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];
  logic        p1 = 1'b0;
  logic [31:0] a1 = 32'd0;
  int          mcnt = 0;
  logic [31:0] mlog [0:63];
  always @(posedge clk) begin
    p1 <= mem_req;
    a1 <= mem_addr;
    mem_rvalid <= p1;
    mem_rdata  <= mem[a1[9:2]];
    if (mem_req) begin
      mlog[mcnt % 64] <= mem_addr;
      mcnt <= mcnt + 1;
    end
  end

  int          icnt = 0;
  logic [31:0] l_addr [0:15];
  logic [15:0] l_len [0:15];
  logic        l_dir [0:15];
  logic [2:0]  l_mode [0:15];
  logic        l_frag [0:15];
  int          ecnt = 0;
  always @(posedge clk) begin
    xfer_done <= 1'b0;
    if (xfer_start) begin
      l_addr[icnt % 16] <= xfer_addr;
      l_len[icnt % 16]  <= xfer_len;
      l_dir[icnt % 16]  <= xfer_dir;
      l_mode[icnt % 16] <= xfer_mode;
      l_frag[icnt % 16] <= xfer_frag;
      icnt <= icnt + 1;
      ecnt <= int'(xfer_len[1:0]) + 1;
    end else if (ecnt != 0) begin
      ecnt <= ecnt - 1;
      if (ecnt == 1) xfer_done <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_end();
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      rd(3'd2, s);
      if (s != 0) break;
    end
  endtask

  function automatic logic [31:0] daddr(input int i);
    return 32'h40 + 32'(i) * 32'h10;
  endfunction

  function automatic logic [31:0] baddr(input int i, input int v);
    return 32'h8000_0000 + 32'(i) * 32'h40 + 32'(v) * 32'h400;
  endfunction

  function automatic logic [31:0] cword(input int len, input int frag, input int mode, input int dir);
    return (32'(len) << 16) | (32'(frag) << 8) | (32'(mode) << 1) | 32'(dir);
  endfunction

  task automatic build(input int n, input int v, input int bad);
    for (int i = 0; i < n; i++) begin
      mem[daddr(i)[9:2]]     = (i == bad) ? baddr(i, v) + 32'h10 : baddr(i, v);
      mem[daddr(i)[9:2] + 1] = (i == n - 1) ? 32'd0 : daddr(i + 1);
      mem[daddr(i)[9:2] + 2] = cword(4 + 3 * i + 16 * v, (i != n - 1) ? 1 : 0,
                                     (i + v) % 8, (i + v) & 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int i0, m0;
    for (int k = 0; k < 256; k++) mem[k] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R10 mem_req", {31'd0, mem_req}, 0);
    chk("R10 xfer_start", {31'd0, xfer_start}, 0);
    chk("R10 irq", {31'd0, irq}, 0);
    rd(3'd2, r); chk("R10 status", r, 0);
    rd(3'd1, r); chk("R10 enable", r, 0);
    rd(3'd3, r); chk("R10 cur desc", r, 0);
    rd(3'd4, r); chk("R10 cur buf", r, 0);

    // sweep over chain lengths and field patterns
    for (int v = 0; v < 2; v++) begin
      for (int n = 1; n <= 4; n++) begin
        build(n, v, -1);
        i0 = icnt; m0 = mcnt;
        wr(3'd0, daddr(0));
        wait_end();
        chk("R3 issued count", 32'(icnt - i0), 32'(n));
        chk("R9 read count", 32'(mcnt - m0), 32'(3 * n));
        for (int i = 0; i < n; i++) begin
          for (int w = 0; w < 3; w++)
            chk("R1 fetch addr", mlog[(m0 + 3 * i + w) % 64], daddr(i) + 32'(4 * w));
          chk("R2 addr", l_addr[(i0 + i) % 16], baddr(i, v));
          chk("R2 len", {16'd0, l_len[(i0 + i) % 16]}, 32'(4 + 3 * i + 16 * v));
          chk("R2 dir", {31'd0, l_dir[(i0 + i) % 16]}, 32'((i + v) & 1));
          chk("R2 mode", {29'd0, l_mode[(i0 + i) % 16]}, 32'((i + v) % 8));
          chk("R2 frag", {31'd0, l_frag[(i0 + i) % 16]}, (i != n - 1) ? 1 : 0);
        end
        rd(3'd2, r); chk("R4 done bit", r, 32'h8000_0000);
        rd(3'd3, r); chk("R7 cur desc", r, daddr(n - 1));
        rd(3'd4, r); chk("R7 cur buf", r, baddr(n - 1, v));
        chk("R6 irq masked", {31'd0, irq}, 0);
        wr(3'd2, 32'h8000_0000);
        rd(3'd2, r); chk("R6 w1c clear", r, 0);
      end
    end

    // interrupt enable and write-one-to-clear
    build(1, 0, -1);
    wr(3'd0, daddr(0));
    wait_end();
    wr(3'd1, 32'h8000_0000);
    #0.5; chk("R6 irq on done", {31'd0, irq}, 1);
    wr(3'd2, 32'h0000_0002);
    rd(3'd2, r); chk("R6 zero write keeps", r, 32'h8000_0000);
    wr(3'd2, 32'h8000_0000);
    #0.5; chk("R6 irq after clear", {31'd0, irq}, 0);

    // misaligned buffer in middle of chain
    build(3, 1, 1);
    wr(3'd1, 32'h0000_0002);
    i0 = icnt;
    wr(3'd0, daddr(0));
    wait_end();
    repeat (20) @(negedge clk);
    chk("R5 issued before stop", 32'(icnt - i0), 1);
    rd(3'd2, r); chk("R5 err bit only", r, 32'h0000_0002);
    rd(3'd3, r); chk("R5 stopped desc", r, daddr(1));
    rd(3'd4, r); chk("R7 misaligned buf", r, baddr(1, 1) + 32'h10);
    #0.5; chk("R6 irq on err", {31'd0, irq}, 1);
    wr(3'd2, 32'h0000_0002);
    rd(3'd2, r); chk("R6 err clear", r, 0);
    wr(3'd1, 32'h0);

    // launch during a walk is ignored
    build(3, 1, -1);
    mem[8'hF0] = 32'h8000_0000; mem[8'hF1] = 32'd0; mem[8'hF2] = cword(1, 0, 0, 0);
    i0 = icnt;
    wr(3'd0, daddr(0));
    repeat (4) @(negedge clk);
    wr(3'd0, 32'h3C0);
    wait_end();
    repeat (40) @(negedge clk);
    chk("R8 issued count", 32'(icnt - i0), 3);
    rd(3'd3, r); chk("R8 cur desc", r, daddr(2));
    chk("R8 last addr", l_addr[(i0 + 2) % 16], baddr(2, 1));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule